// File: doc/BRIEF.md
# Serial Number CRC-8 Verifier

This block checks an eight-byte read-only identification number as it is received, one byte per clock, from whatever front end fetched it. The bytes arrive from the most significant (byte 7) down to byte 0. The first two bytes carry a 16-bit customer identifier, and the next five carry a 40-bit unique number. The last byte is a CRC-8 check value computed by the issuer over the seven bytes before it.

A `start_i` pulse opens a new check. Each cycle with `valid_i` high hands over one byte. While the first seven bytes stream in, the block folds each one into a running CRC through a combinational byte-wide next-state function, so no lookup table is stored. On the eighth byte it compares the running CRC with the received check byte. It then raises `done_o` for one cycle and holds `match_o` and the split fields until the next start.

Top module: `sn_crc_checker`

## Requirements
- R1: While reset is asserted, and after it until the first accepted byte, `done_o`, `match_o`, `cust_id_o` and `uid_o` are all zero, and the next accepted byte is treated as the first byte of a number.
- R2: After the eighth byte, `cust_id_o` holds the first accepted byte in bits 15:8 and the second in bits 7:0. `uid_o` holds bytes three to seven, with the third in bits 39:32 and the seventh in bits 7:0.
- R3: The CRC starts from 00h and uses polynomial 07h (x^8+x^2+x+1). Bits are taken most significant first, with no reflection and no final XOR, over the first seven bytes in arrival order. Six 00h bytes followed by 01h yield 07h.
- R4: `match_o` goes high exactly when the computed CRC equals the eighth byte. It changes only together with `done_o` or on a start, and it holds its value in between.
- R5: `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the eighth byte.
- R6: `start_i` clears the byte count, the CRC, `match_o` and both fields. A byte offered with `valid_i` in the same cycle as `start_i` is discarded.
- R7: Valid bytes after the eighth are ignored until the next start. They cause no `done_o` pulse and leave `match_o` and the fields unchanged.
- R8: Cycles with `valid_i` low do not advance the check, so gaps between bytes give the same result as back-to-back bytes. An unassigned customer identifier of two 00h bytes is reported as 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Opens a new check and clears all state |
| valid_i | input | 1 | `sn_byte_i` carries the next byte this cycle |
| sn_byte_i | input | 8 | Incoming serial-number byte, most significant byte first |
| done_o | output | 1 | One-cycle pulse after the eighth byte |
| match_o | output | 1 | Computed CRC equalled the check byte; held until next start |
| cust_id_o | output | 16 | Customer identifier field |
| uid_o | output | 40 | Unique number field |

## Verification
A wrong byte count shows at the ports as a `done_o` pulse that comes early, comes late or never comes. It also shows as fields shifted by a byte, all within the frame in which it occurs. A corrupted CRC state appears only at the end of the frame, as a wrong `match_o` in the `done_o` cycle. For that reason the bench sends frames with both correct and deliberately damaged check bytes. Leaks across frames (a missed clear on start, or bytes accepted after the eighth) show as fields or `match_o` that differ from the model in the cycles right after the disturbing stimulus.

// File: rtl/sncrc_pkg.sv
package sncrc_pkg;
  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_SN_BYTES   = 8;
  localparam int unsigned DEF_CUST_BYTES = 2;
  localparam logic [7:0]  DEF_POLY       = 8'h07;
  localparam logic [7:0]  DEF_INIT       = 8'h00;
endpackage

// File: rtl/sncrc_rst_sync.sv
module sncrc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/sncrc_step.sv
module sncrc_step #(
  parameter int unsigned      BYTE_W = 8,
  parameter logic [BYTE_W-1:0] POLY  = 8'h07
) (
  input  logic [BYTE_W-1:0] crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] crc_o
);
  logic [BYTE_W-1:0] stg [BYTE_W+1];

  assign stg[0] = crc_i ^ data_i;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    logic [BYTE_W-1:0] shifted;
    assign shifted    = {stg[k][BYTE_W-2:0], 1'b0};
    assign stg[k+1]   = stg[k][BYTE_W-1] ? (shifted ^ POLY) : shifted;
  end

  assign crc_o = stg[BYTE_W];
endmodule

// File: rtl/sncrc_ctrl.sv
module sncrc_ctrl #(
  parameter int unsigned SN_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic take_o,
  output logic last_o,
  output logic full_o,
  output logic done_o
);
  localparam int unsigned      CNT_W    = $clog2(SN_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SN_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SN_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             accept;
  logic             done_q, done_d;

  assign full_o = (cnt_q == CNT_FULL);
  assign accept = valid_i & ~start_i & ~full_o;
  assign take_o = accept & (cnt_q != CNT_LAST);
  assign last_o = accept & (cnt_q == CNT_LAST);

  always_comb begin
    cnt_en = start_i | accept;
    cnt_d  = cnt_q;
    if (start_i)     cnt_d = '0;
    else if (accept) cnt_d = cnt_q + CNT_ONE;
    done_d = last_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done_o = done_q;

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: the count never runs past the frame length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R7: a completed frame produces no further done pulse
  a_r7_full_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !start_i) |=> !done_q);

  // R6: a start returns the count to zero and suppresses done
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/sncrc_fields.sv
module sncrc_fields #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SN_BYTES = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           shift_i,
  input  logic [BYTE_W-1:0]              byte_i,
  output logic [(SN_BYTES-1)*BYTE_W-1:0] body_o
);
  localparam int unsigned BODY_W = (SN_BYTES - 1) * BYTE_W;

  logic [BODY_W-1:0] body_q, body_d;
  logic              body_en;

  always_comb begin
    body_en = clear_i | shift_i;
    if (clear_i) body_d = '0;
    else         body_d = {body_q[BODY_W-BYTE_W-1:0], byte_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       body_q <= '0;
    else if (body_en) body_q <= body_d;
  end

  assign body_o = body_q;
endmodule

// File: rtl/sn_crc_checker.sv
module sn_crc_checker
  import sncrc_pkg::*;
#(
  parameter int unsigned       BYTE_W     = DEF_BYTE_W,
  parameter int unsigned       SN_BYTES   = DEF_SN_BYTES,
  parameter int unsigned       CUST_BYTES = DEF_CUST_BYTES,
  parameter logic [BYTE_W-1:0] POLY       = DEF_POLY,
  parameter logic [BYTE_W-1:0] CRC_INIT   = DEF_INIT
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start_i,
  input  logic                                        valid_i,
  input  logic [BYTE_W-1:0]                           sn_byte_i,
  output logic                                        done_o,
  output logic                                        match_o,
  output logic [CUST_BYTES*BYTE_W-1:0]                cust_id_o,
  output logic [(SN_BYTES-1-CUST_BYTES)*BYTE_W-1:0]   uid_o
);
  localparam int unsigned BODY_W = (SN_BYTES - 1) * BYTE_W;
  localparam int unsigned CUST_W = CUST_BYTES * BYTE_W;
  localparam int unsigned UID_W  = BODY_W - CUST_W;

  logic              rst_ns;
  logic              take, last, full;
  logic [BYTE_W-1:0] crc_q, crc_d, crc_step;
  logic              crc_en;
  logic              match_q, match_d, match_en;
  logic [BODY_W-1:0] body;

  sncrc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  sncrc_ctrl #(.SN_BYTES(SN_BYTES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_ns),
    .start_i (start_i),
    .valid_i (valid_i),
    .take_o  (take),
    .last_o  (last),
    .full_o  (full),
    .done_o  (done_o)
  );

  sncrc_step #(.BYTE_W(BYTE_W), .POLY(POLY)) u_step (
    .crc_i  (crc_q),
    .data_i (sn_byte_i),
    .crc_o  (crc_step)
  );

  sncrc_fields #(.BYTE_W(BYTE_W), .SN_BYTES(SN_BYTES)) u_fields (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clear_i (start_i),
    .shift_i (take),
    .byte_i  (sn_byte_i),
    .body_o  (body)
  );

  always_comb begin
    crc_en = start_i | take;
    crc_d  = start_i ? CRC_INIT : crc_step;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     crc_q <= CRC_INIT;
    else if (crc_en) crc_q <= crc_d;
  end

  always_comb begin
    match_en = start_i | last;
    match_d  = start_i ? 1'b0 : (crc_q == sn_byte_i);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       match_q <= 1'b0;
    else if (match_en) match_q <= match_d;
  end

  assign match_o   = match_q;
  assign cust_id_o = body[BODY_W-1 -: CUST_W];
  assign uid_o     = body[UID_W-1:0];

  // R4: the match flag only moves on a start or with the check byte
  a_r4_match_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!start_i && !last) |=> $stable(match_q));

  // R4: a new match appears together with the done pulse
  a_r4_match_with_done: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(match_q) |-> done_o);

  // R7: fields are frozen once the frame is complete
  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (!rst_ns)
    (full && !start_i) |=> $stable(body));

  // R6: a start clears the result and the fields
  a_r6_start_clears_result: assert property (@(posedge clk) disable iff (!rst_ns)
    start_i |=> (!match_q && (body == '0)));
endmodule

// File: tb/sn_crc_checker_tb.sv
module sn_crc_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  sn_byte_i = 8'h00;
  logic        done_o, match_o;
  logic [15:0] cust_id_o;
  logic [39:0] uid_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int         m_cnt = 0;
  logic [7:0] m_crc = 8'h00;
  logic       m_done = 1'b0;
  logic       m_match = 1'b0;
  logic [7:0] m_b [8];

  always #2 clk = ~clk;

  sn_crc_checker u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .valid_i   (valid_i),
    .sn_byte_i (sn_byte_i),
    .done_o    (done_o),
    .match_o   (match_o),
    .cust_id_o (cust_id_o),
    .uid_o     (uid_o)
  );

  // bit-serial LFSR form of the CRC, MSB first
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  function automatic logic [63:0] mk_frame(input logic [55:0] body);
    logic [7:0] c;
    c = 8'h00;
    for (int k = 0; k < 7; k++) c = ref_crc(c, body[55-8*k -: 8]);
    return {body, c};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model advances on every rising edge from the inputs held stable there
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_crc = 8'h00; m_done = 1'b0; m_match = 1'b0;
      for (int k = 0; k < 8; k++) m_b[k] = 8'h00;
    end else begin
      m_done = 1'b0;
      if (start_i) begin
        m_cnt = 0; m_crc = 8'h00; m_match = 1'b0;
        for (int k = 0; k < 8; k++) m_b[k] = 8'h00;
      end else if (valid_i && m_cnt < 8) begin
        m_b[m_cnt] = sn_byte_i;
        if (m_cnt < 7) m_crc = ref_crc(m_crc, sn_byte_i);
        else begin
          m_done  = 1'b1;
          m_match = (m_crc == sn_byte_i);
        end
        m_cnt++;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    chk("R5 done pulse", {63'd0, done_o}, {63'd0, m_done});
    chk("R4 match flag", {63'd0, match_o}, {63'd0, m_match});
    if (m_cnt == 8 || m_cnt == 0) begin
      chk("R2 customer field", {48'd0, cust_id_o}, {48'd0, m_b[0], m_b[1]});
      chk("R2 unique field", {24'd0, uid_o}, {24'd0, m_b[2], m_b[3], m_b[4], m_b[5], m_b[6]});
    end
  end

  task automatic put(input logic s, input logic v, input logic [7:0] b);
    @(negedge clk);
    start_i = s; valid_i = v; sn_byte_i = b;
    @(posedge clk);
    #1;
    start_i = 1'b0; valid_i = 1'b0; sn_byte_i = 8'h00;
  endtask

  task automatic send_frame(input logic [63:0] f, input int gap);
    put(1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 8; k++) begin
      put(1'b0, 1'b1, f[63-8*k -: 8]);
      if (k < 7) repeat (gap) put(1'b0, 1'b0, 8'h00);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [63:0] fr;
    logic [55:0] bd;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 reset done", {63'd0, done_o}, 64'd0);
    chk("R1 reset match", {63'd0, match_o}, 64'd0);
    chk("R1 reset fields", {8'd0, cust_id_o, uid_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) put(1'b0, 1'b0, 8'h00);

    // R1: bytes without a prior start form a frame
    for (int k = 0; k < 8; k++) put(1'b0, 1'b1, (k == 7) ? 8'h07 : ((k == 6) ? 8'h01 : 8'h00));
    @(negedge clk);
    chk("R1 first frame after reset done", {63'd0, done_o}, 64'd1);

    // R3: known vector, six zeros and 01h give 07h
    send_frame(64'h0000_0000_0000_0107, 0);
    @(negedge clk);
    chk("R3 known vector done", {63'd0, done_o}, 64'd1);
    chk("R3 known vector match", {63'd0, match_o}, 64'd1);
    @(negedge clk);
    chk("R5 done drops", {63'd0, done_o}, 64'd0);

    // R4: wrong check byte
    send_frame(64'h0000_0000_0000_0106, 0);
    @(negedge clk);
    chk("R4 bad crc no match", {63'd0, match_o}, 64'd0);

    // R2: field split
    fr = mk_frame(56'hA53C_1122334455);
    send_frame(fr, 0);
    @(negedge clk);
    chk("R2 customer id", {48'd0, cust_id_o}, 64'h0000_0000_0000_A53C);
    chk("R2 unique number", {24'd0, uid_o}, 64'h0000_0011_2233_4455);
    chk("R2 match", {63'd0, match_o}, 64'd1);

    // R7: extra bytes after the eighth are ignored
    repeat (3) put(1'b0, 1'b1, 8'hEE);
    @(negedge clk);
    chk("R7 fields unchanged", {24'd0, uid_o}, 64'h0000_0011_2233_4455);
    chk("R7 match unchanged", {63'd0, match_o}, 64'd1);
    chk("R7 no done", {63'd0, done_o}, 64'd0);

    // R8: gaps and default customer id
    fr = mk_frame(56'h0000_DEADBEEF01);
    send_frame(fr, 3);
    @(negedge clk);
    chk("R8 gapped frame match", {63'd0, match_o}, 64'd1);
    chk("R8 default customer id", {48'd0, cust_id_o}, 64'd0);

    // R6: start mid-frame, and start with a simultaneous valid byte
    put(1'b1, 1'b0, 8'h00);
    repeat (3) put(1'b0, 1'b1, 8'h5A);
    fr = mk_frame(56'h1234_A0B0C0D0E0);
    put(1'b1, 1'b1, 8'hFF);
    for (int k = 0; k < 8; k++) put(1'b0, 1'b1, fr[63-8*k -: 8]);
    @(negedge clk);
    chk("R6 restart match", {63'd0, match_o}, 64'd1);
    chk("R6 restart customer id", {48'd0, cust_id_o}, 64'h1234);
    put(1'b1, 1'b0, 8'h00);
    @(negedge clk);
    chk("R6 start clears match", {63'd0, match_o}, 64'd0);
    chk("R6 start clears fields", {8'd0, cust_id_o, uid_o}, 64'd0);

    // R3/R4: random frames, some damaged
    for (int n = 0; n < 40; n++) begin
      bd = {$urandom, $urandom};
      fr = mk_frame(bd);
      if (n % 3 == 1) fr[7:0] = fr[7:0] ^ 8'h10;
      if (n % 5 == 2) fr[30] = ~fr[30];
      send_frame(fr, n % 3);
      @(negedge clk);
      chk("R3 random frame match", {63'd0, match_o},
          {63'd0, (n % 3 != 1) && (n % 5 != 2)});
    end

    repeat (4) put(1'b0, 1'b0, 8'h00);
    summary();
  end
endmodule